// File: doc/BRIEF.md
# Dual-Function Power-State Controller

This block governs the power state of the two functions of a dual-function bus device. For each function it keeps a command register and a two-bit power-state field, both loaded through dedicated write strobes. From these it derives the gated command enables that the rest of the function uses and a core low-power request. It also derives a soft-reset output and the interrupt lines seen by the host, plus one enable for a clock multiplier shared by both functions.

In the light sleep state (D2) the decode, bus-master and error-reporting enables are hidden while their stored values survive. Interrupts are held back and remembered for delivery on wake. In the deepest state (D3) the function is kept in soft reset and its command register is wiped. The shared clock multiplier is only switched off when both functions sleep in D3 together. A power-on reset returns everything to D0, which models the return from a power-removed state.

Top module: `pwrStateCtl`

## Requirements
- R1: After power-on reset (rstN low) every function reads D0, its command register and held interrupts are zero, softRst and coreSleep are low, intOut is zero and clkMulEn is high.
- R2: The state field uses 00=D0, 01=D1, 10=D2, 11=D3. A pmWrEn write shows on pwrState one clock later. A cmdWrEn write shows on cmdStored one clock later, unless R8 blocks it.
- R3: In D0 and D1, cmdEff equals cmdStored and intOut equals intSrc OR the held-interrupt bits.
- R4: In D2 and D3, cmdEff has bits 0 (I/O decode), 1 (memory decode), 2 (bus master), 6 (parity response) and 8 (SERR) forced to zero, and every other bit follows cmdStored. In D2, cmdStored keeps its value and still accepts writes.
- R5: In D2, intOut is zero. On every clock spent in D2, the intSrc bits that are high are ORed into the held-interrupt register.
- R6: After a move from D2 to D1 or D0, the stored command bits reappear on cmdEff. Each held bit drives its intOut line until a clock with the matching intAck bit high clears it.
- R7: coreSleep is high exactly while the function is in D2 or D3.
- R8: While in D3, softRst is high and intOut is zero. Held interrupts are cleared and cmdStored is zero from the entry clock on, and command writes are ignored.
- R9: From D3 only a write of D0 is accepted; writes of D1, D2 or D3 leave the state in D3. On leaving D3, softRst drops one clock after the write and cmdStored stays zero until written.
- R10: clkMulEn is low exactly when both functions are in D3 at once.
- R11: Asserting rstN at any time returns both functions to the R1 state, whatever state they were in.
- R12: The writes, interrupts and states of one function have no effect on the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| cmdWrEn | input | NUM_FUNC | Command register write strobe, one per function |
| cmdWrData | input | NUM_FUNC*CMD_W | Command write data, function i at [i*CMD_W +: CMD_W] |
| pmWrEn | input | NUM_FUNC | Power-state write strobe, one per function |
| pmWrData | input | NUM_FUNC*2 | Requested state per function, encoding as in R2 |
| intSrc | input | NUM_FUNC*INT_W | Level interrupt sources (SCSI, DMA) per function |
| intAck | input | NUM_FUNC*INT_W | Clears held interrupt bits per function |
| pwrState | output | NUM_FUNC*2 | Current power state per function |
| cmdStored | output | NUM_FUNC*CMD_W | Stored command register per function |
| cmdEff | output | NUM_FUNC*CMD_W | Gated command enables per function |
| intOut | output | NUM_FUNC*INT_W | Interrupt lines presented to the host |
| coreSleep | output | NUM_FUNC | Core low-power request per function |
| softRst | output | NUM_FUNC | Soft reset per function |
| clkMulEn | output | 1 | Shared clock-multiplier enable |

## Verification
The bench drives an interrupt into D2 and wakes the function while the source has already dropped. A design that replays only live sources would lose that interrupt. It writes D1 and D2 into a function sitting in D3, which a controller accepting any exit would let out of soft reset. It puts only one function into D3 to catch a multiplier enable decoded from a single function, and it writes the command register during D3 and right after the exit so that a design restoring the old value shows stale enables. A long pseudo-random phase with interleaved writes on both functions, followed by a mid-run reset, exposes cross-talk between functions and any state that a reset fails to clear.

// File: rtl/pwrPkg.sv
package pwrPkg;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pwrState_e;

  // strobes from the per-function control to its datapath
  typedef struct packed {
    logic gate;      // hide decode / master / error enables
    logic blockInt;  // keep interrupt lines low
    logic capture;   // OR live sources into the held register
    logic clrAll;    // wipe command and held interrupts
    logic ldCmd;     // load command register from write data
  } fnStrobe_t;

  localparam int BIT_IO   = 0;
  localparam int BIT_MEM  = 1;
  localparam int BIT_BM   = 2;
  localparam int BIT_PERR = 6;
  localparam int BIT_SERR = 8;

  function automatic logic [31:0] sleepMask();
    logic [31:0] m;
    m = '0;
    m[BIT_IO]   = 1'b1;
    m[BIT_MEM]  = 1'b1;
    m[BIT_BM]   = 1'b1;
    m[BIT_PERR] = 1'b1;
    m[BIT_SERR] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pwrFnCtrl.sv
module pwrFnCtrl
  import pwrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pmWrEn,
  input  logic [1:0] pmWrData,
  input  logic       cmdWrEn,
  output pwrState_e  state,
  output fnStrobe_t  strb
);

  pwrState_e reqState;
  logic      acceptWr;
  logic      enterD3;
  logic      inD3;

  assign reqState = pwrState_e'(pmWrData);
  assign inD3     = (state == PS_D3);
  // from D3 the only way out is an explicit D0 request
  assign acceptWr = pmWrEn && (!inD3 || (reqState == PS_D0));
  assign enterD3  = acceptWr && !inD3 && (reqState == PS_D3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= PS_D0;
    end else if (acceptWr) begin
      state <= reqState;
    end
  end

  always_comb begin
    strb          = '0;
    strb.gate     = (state == PS_D2) || inD3;
    strb.blockInt = (state == PS_D2) || inD3;
    strb.capture  = (state == PS_D2);
    strb.clrAll   = inD3 || enterD3;
    strb.ldCmd    = cmdWrEn && !(inD3 || enterD3);
  end

  AST_D3_EXIT_ONLY_D0: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_D3) |=> (state == PS_D3) || (state == PS_D0)); // R9

  AST_D3_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_D3) && !pmWrEn |=> (state == PS_D3)); // R9

endmodule

// File: rtl/pwrFnData.sv
module pwrFnData
  import pwrPkg::*;
#(
  parameter int CMD_W = 11,
  parameter int INT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  fnStrobe_t        strb,
  input  logic [CMD_W-1:0] cmdWrData,
  input  logic [INT_W-1:0] intSrc,
  input  logic [INT_W-1:0] intAck,
  output logic [CMD_W-1:0] cmdReg,
  output logic [CMD_W-1:0] cmdEff,
  output logic [INT_W-1:0] intOut
);

  localparam logic [31:0]      MASK_FULL = sleepMask();
  localparam logic [CMD_W-1:0] GATE_MASK = MASK_FULL[CMD_W-1:0];

  logic [INT_W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strb.clrAll) begin
      cmdReg <= '0;
    end else if (strb.ldCmd) begin
      cmdReg <= cmdWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held <= '0;
    end else if (strb.clrAll) begin
      held <= '0;
    end else if (strb.capture) begin
      held <= held | intSrc;
    end else begin
      held <= held & ~intAck;
    end
  end

  assign cmdEff = strb.gate ? (cmdReg & ~GATE_MASK) : cmdReg;
  assign intOut = strb.blockInt ? '0 : (intSrc | held);

  AST_WIPE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (cmdReg == '0)); // R8

  AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !strb.clrAll |=> ((held & $past(held)) == $past(held))); // R5

endmodule

// File: rtl/pwrStateCtl.sv
module pwrStateCtl
  import pwrPkg::*;
#(
  parameter int NUM_FUNC = 2,
  parameter int CMD_W    = 11,
  parameter int INT_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_FUNC-1:0]       cmdWrEn,
  input  logic [NUM_FUNC*CMD_W-1:0] cmdWrData,
  input  logic [NUM_FUNC-1:0]       pmWrEn,
  input  logic [NUM_FUNC*2-1:0]     pmWrData,
  input  logic [NUM_FUNC*INT_W-1:0] intSrc,
  input  logic [NUM_FUNC*INT_W-1:0] intAck,
  output logic [NUM_FUNC*2-1:0]     pwrState,
  output logic [NUM_FUNC*CMD_W-1:0] cmdStored,
  output logic [NUM_FUNC*CMD_W-1:0] cmdEff,
  output logic [NUM_FUNC*INT_W-1:0] intOut,
  output logic [NUM_FUNC-1:0]       coreSleep,
  output logic [NUM_FUNC-1:0]       softRst,
  output logic                      clkMulEn
);

  localparam logic [31:0]      MASK_FULL = sleepMask();
  localparam logic [CMD_W-1:0] GATE_MASK = MASK_FULL[CMD_W-1:0];

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
    pwrState_e fnState;
    fnStrobe_t fnStrb;

    pwrFnCtrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .pmWrEn   (pmWrEn[i]),
      .pmWrData (pmWrData[i*2 +: 2]),
      .cmdWrEn  (cmdWrEn[i]),
      .state    (fnState),
      .strb     (fnStrb)
    );

    pwrFnData #(.CMD_W(CMD_W), .INT_W(INT_W)) u_data (
      .clk       (clk),
      .rstN      (rstN),
      .strb      (fnStrb),
      .cmdWrData (cmdWrData[i*CMD_W +: CMD_W]),
      .intSrc    (intSrc[i*INT_W +: INT_W]),
      .intAck    (intAck[i*INT_W +: INT_W]),
      .cmdReg    (cmdStored[i*CMD_W +: CMD_W]),
      .cmdEff    (cmdEff[i*CMD_W +: CMD_W]),
      .intOut    (intOut[i*INT_W +: INT_W])
    );

    assign pwrState[i*2 +: 2] = fnState;
    assign coreSleep[i]       = (fnState == PS_D2) || (fnState == PS_D3);
    assign softRst[i]         = (fnState == PS_D3);

    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rstN)
      coreSleep[i] |-> ((cmdEff[i*CMD_W +: CMD_W] & GATE_MASK) == '0)); // R4

    AST_AWAKE_PASS: assert property (@(posedge clk) disable iff (!rstN)
      !coreSleep[i] |-> (cmdEff[i*CMD_W +: CMD_W] == cmdStored[i*CMD_W +: CMD_W])); // R3

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      softRst[i] |-> (intOut[i*INT_W +: INT_W] == '0) && (cmdStored[i*CMD_W +: CMD_W] == '0)); // R8
  end

  assign clkMulEn = ~&softRst;

  AST_CLK_OFF_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !clkMulEn |-> (&coreSleep) && (&softRst)); // R10

endmodule

// File: tb/sim_pwrStateCtl.sv
module sim_pwrStateCtl;
  localparam int NF = 2;
  localparam int CW = 11;
  localparam int IW = 2;
  localparam logic [CW-1:0] MASK = 11'h147; // bits 0,1,2,6,8

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NF-1:0] cmdWrEn = '0;
  logic [NF*CW-1:0] cmdWrData = '0;
  logic [NF-1:0] pmWrEn = '0;
  logic [NF*2-1:0] pmWrData = '0;
  logic [NF*IW-1:0] intSrc = '0;
  logic [NF*IW-1:0] intAck = '0;
  logic [NF*2-1:0] pwrState;
  logic [NF*CW-1:0] cmdStored, cmdEff;
  logic [NF*IW-1:0] intOut;
  logic [NF-1:0] coreSleep, softRst;
  logic clkMulEn;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  string forceTag = "";

  always #2 clk = ~clk; // 250 MHz

  pwrStateCtl u0 (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .pmWrEn(pmWrEn), .pmWrData(pmWrData), .intSrc(intSrc), .intAck(intAck),
    .pwrState(pwrState), .cmdStored(cmdStored), .cmdEff(cmdEff),
    .intOut(intOut), .coreSleep(coreSleep), .softRst(softRst), .clkMulEn(clkMulEn)
  );

  // behavioural reference
  int mSt[NF];
  logic [CW-1:0] mCmd[NF];
  logic [IW-1:0] mHeld[NF];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < NF; f++) begin
        mSt[f] = 0; mCmd[f] = '0; mHeld[f] = '0;
      end
    end else begin
      for (int f = 0; f < NF; f++) begin
        int req;
        int nxt;
        bit wipe;
        req = int'(pmWrData[f*2 +: 2]);
        nxt = mSt[f];
        if (pmWrEn[f]) begin
          if (mSt[f] != 3) nxt = req;
          else if (req == 0) nxt = 0;
        end
        wipe = (mSt[f] == 3) || (nxt == 3);
        if (wipe) mCmd[f] = '0;
        else if (cmdWrEn[f]) mCmd[f] = cmdWrData[f*CW +: CW];
        if (wipe) mHeld[f] = '0;
        else if (mSt[f] == 2) mHeld[f] = mHeld[f] | intSrc[f*IW +: IW];
        else mHeld[f] = mHeld[f] & ~intAck[f*IW +: IW];
        mSt[f] = nxt;
      end
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string pick(string dflt);
    return (forceTag != "") ? forceTag : dflt;
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [CW-1:0] eEff;
    logic [IW-1:0] eInt;
    bit bothD3;
    cyc++;
    bothD3 = 1'b1;
    for (int f = 0; f < NF; f++) begin
      string tE, tI;
      eEff = (mSt[f] >= 2) ? (mCmd[f] & ~MASK) : mCmd[f];
      eInt = (mSt[f] < 2) ? (intSrc[f*IW +: IW] | mHeld[f]) : '0;
      if (mSt[f] != 3) bothD3 = 1'b0;
      tE = (mSt[f] == 3) ? "R8" : (mSt[f] == 2) ? "R4" : "R3";
      tI = (mSt[f] == 3) ? "R8" : (mSt[f] == 2) ? "R5" : (mHeld[f] != 0) ? "R6" : "R3";
      chk(pick("R2"), "pwrState", longint'(pwrState[f*2 +: 2]), longint'(mSt[f]));
      chk(pick((mSt[f] == 3) ? "R8" : "R2"), "cmdStored", longint'(cmdStored[f*CW +: CW]), longint'(mCmd[f]));
      chk(pick(tE), "cmdEff", longint'(cmdEff[f*CW +: CW]), longint'(eEff));
      chk(pick(tI), "intOut", longint'(intOut[f*IW +: IW]), longint'(eInt));
      chk(pick("R7"), "coreSleep", longint'(coreSleep[f]), longint'(mSt[f] >= 2));
      chk(pick("R8"), "softRst", longint'(softRst[f]), longint'(mSt[f] == 3));
    end
    chk(pick("R10"), "clkMulEn", longint'(clkMulEn), longint'(!bothD3));
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      cmdWrEn = '0; pmWrEn = '0; intAck = '0;
    end
  endtask

  task automatic setPm(int f, int s);
    pmWrEn[f] = 1'b1; pmWrData[f*2 +: 2] = s[1:0];
  endtask

  task automatic setCmd(int f, logic [CW-1:0] v);
    cmdWrEn[f] = 1'b1; cmdWrData[f*CW +: CW] = v;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      nFail++;
      $display("FAIL watchdog expired: actual %0d expected below 20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    forceTag = "R1";
    #1; tick(3);
    rstN = 1'b1; tick(1);
    forceTag = "";
    // R2: load command registers, walk state encodings
    setCmd(0, 11'h7FF); setCmd(1, 11'h145); tick(2);
    intSrc = 4'b1001; tick(2);                 // R3 in D0
    setPm(0, 1); tick(2);                      // R3 in D1
    // R4 / R5: D2 with source high, then source drops
    setPm(0, 2); tick(1);
    intSrc[1:0] = 2'b00; tick(2);
    intSrc[1:0] = 2'b10; tick(1);
    intSrc[1:0] = 2'b00;
    setCmd(0, 11'h3C3); tick(2);               // write kept while gated
    // R6: wake to D0, held bits replay until acked
    setPm(0, 0); tick(3);
    intAck[0] = 1'b1; tick(2);
    intAck[1] = 1'b1; tick(2);
    // R8 / R10: function 0 alone in D3, multiplier stays on
    setPm(0, 3); setCmd(0, 11'h0FF); tick(2);
    setCmd(0, 11'h055); intSrc[1:0] = 2'b11; tick(2);
    forceTag = "R12";
    setCmd(1, 11'h1F0); tick(2);               // function 1 unaffected
    forceTag = "";
    setPm(1, 3); tick(3);                      // both in D3
    // R9: illegal exits ignored
    setPm(0, 1); tick(1); setPm(0, 2); tick(1); setPm(0, 3); tick(2);
    setPm(0, 0); setCmd(0, 11'h7FF); tick(1);  // exit with a write ignored
    tick(2);
    setCmd(0, 11'h00F); tick(2);
    setPm(1, 0); tick(2);
    intSrc = '0; tick(1);
    // pseudo-random phase covering all requirements together
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int f = 0; f < NF; f++) begin
        if (lfsr[f*3 +: 3] == 3'd0) setPm(f, int'(lfsr[12 + f*2 +: 2]));
        if (lfsr[8 + f*3 +: 3] == 3'd1) setCmd(f, lfsr[16 +: CW] ^ CW'(k));
      end
      intSrc = lfsr[27:24];
      intAck = lfsr[31:28] & {4{lfsr[5]}};
      tick(1);
    end
    // R11: reset mid-run from whatever state
    setPm(0, 3); setPm(1, 2); tick(2);
    rstN = 1'b0; forceTag = "R11"; tick(2);
    rstN = 1'b1; tick(2);
    forceTag = "";
    tick(2);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule